// File: doc/BRIEF.md
# Full-Step Stepper Phase Sequencer

This block drives a four-phase unipolar stepper motor in single-coil full-step mode. It produces a 4-bit phase word where a 0 bit switches its coil on (the power stage inverts the logic level). While running, exactly one bit of the word is low. That low bit moves one position per step, toward higher or lower bit indices as the direction input selects.

The step period is set by a 4-bit speed value times a fixed clock prescale. The speed value is taken at each step boundary. A step counter covers one revolution of 48 steps, which is 7.5 degrees per step. In continuous mode the counter wraps and stepping goes on without a break. In one-turn mode the 48th step releases all coils, raises a one-clock done pulse and halts. A new turn needs the run input to fall and rise again. While run is low every coil is released.

Top module: `stepper_fullstep`

## Requirements
- R1: While reset is active, and in every cycle that follows a clock edge at which run_i was low, phase_no is 4'b1111 (all coils released).
- R2: After a clock edge at which run_i is first seen high from the idle state, phase_no is 4'b0111 (bit 3 low) and the step counter starts at 0.
- R3: While running, phase_no has exactly one bit at 0.
- R4: At each step with dir_i=1 the low bit moves from index k to k+1, and from bit 3 to bit 0. This gives 0111, 1110, 1101, 1011, then repeats. With dir_i=0 it moves from k to k-1, and from bit 0 to bit 3. dir_i is read at each step edge.
- R5: A step lasts exactly (speed_i+1)*PRESCALE clock cycles in both directions. speed_i is read at run start and at each step edge, so a change part-way through a step affects only the next step.
- R6: With one_turn_i=0, stepping continues past step 48 without any gap; the counter wraps to 0.
- R7: With one_turn_i=1, at the 48th step edge phase_no becomes 4'b1111 and done_o is high for exactly one cycle. This happens (speed+1)*PRESCALE*48 edges after the run start edge.
- R8: After a completed turn the block stays halted with all coils released for as long as run_i stays high. Only a low and then high run_i starts a new turn from 4'b0111.
- R9: Dropping run_i mid-move releases all coils on the next cycle. The next start begins again from 4'b0111 with a full 48-step count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Run enable |
| dir_i | input | 1 | Direction: 1 moves the low bit upward, 0 moves it downward |
| speed_i | input | 4 | Step period select; the period is (speed_i+1)*PRESCALE cycles |
| one_turn_i | input | 1 | 1: stop after one revolution; 0: run continuously |
| phase_no | output | 4 | Active-low coil drive word |
| done_o | output | 1 | One-cycle pulse when a one-turn move completes |

## Verification
The assertions check on every cycle that:
- the stored pattern stays one-cold;
- the pattern and timer hold between steps;
- the step count never exceeds one revolution;
- run low always releases the coils;
- done is a single-cycle pulse that coincides with released coils;
- a halted block stays released.

Only the bench scenarios can show the timing and the sequences against an independent cycle model. These are the exact step period for each speed, resampling of speed only at the boundary, and the rotation order in both directions. They also cover the wrap at 48 steps in continuous mode, the exact cycle of the done pulse, and the restart rules after a halt or an abort.

// File: rtl/stp_pkg.sv
package stp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } stp_state_e;

endpackage

// File: rtl/step_timer.sv
module step_timer #(
    parameter int PRESCALE = 16,
    parameter int SPEED_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               en_i,
    input  logic [SPEED_W-1:0] speed_i,
    output logic               tick_o
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    typedef struct packed {
        logic [PRE_W-1:0]   pre;
        logic [SPEED_W-1:0] unit;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign tick_o = en_i && (tmr_q.pre == PRE_LAST) && (tmr_q.unit == '0);

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.pre  = '0;
            tmr_d.unit = speed_i;
        end else if (en_i) begin
            if (tick_o) begin
                tmr_d.pre  = '0;
                tmr_d.unit = speed_i;
            end else if (tmr_q.pre == PRE_LAST) begin
                tmr_d.pre  = '0;
                tmr_d.unit = tmr_q.unit - 1'b1;
            end else begin
                tmr_d.pre = tmr_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R5: the timer state is frozen while neither loading nor enabled
    p_timer_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !en_i) |=> $stable(tmr_q));
endmodule

// File: rtl/phase_rotator.sv
module phase_rotator #(
    parameter int PHASES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic              dir_i,
    output logic [PHASES-1:0] pat_o
);
    localparam logic [PHASES-1:0] HOME = {1'b0, {(PHASES-1){1'b1}}};

    logic [PHASES-1:0] pat_d, pat_q;
    logic [PHASES-1:0] up_w, down_w;

    genvar gi;
    generate
        for (gi = 0; gi < PHASES; gi++) begin : g_rot
            assign up_w[(gi + 1) % PHASES]            = pat_q[gi];
            assign down_w[(gi + PHASES - 1) % PHASES] = pat_q[gi];
        end
    endgenerate

    always_comb begin
        pat_d = pat_q;
        if (load_i)      pat_d = HOME;
        else if (step_i) pat_d = dir_i ? up_w : down_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pat_q <= HOME;
        else        pat_q <= pat_d;
    end

    assign pat_o = pat_q;

    // R3: the stored pattern always has exactly one low bit
    p_one_cold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~pat_q) == 1);
    // R5: the pattern only changes at a step or a reload
    p_pat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> $stable(pat_q));
endmodule

// File: rtl/rev_counter.sv
module rev_counter #(
    parameter int STEPS = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic step_i,
    output logic wrap_o
);
    localparam int CNT_W = $clog2(STEPS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEPS - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign wrap_o = step_i && (cnt_q == CNT_LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i)     cnt_d = '0;
        else if (wrap_o) cnt_d = '0;
        else if (step_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R6: the count never leaves the range of one revolution
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LAST);
endmodule

// File: rtl/stepper_fullstep.sv
module stepper_fullstep #(
    parameter int PRESCALE = 16,
    parameter int STEPS    = 48,
    parameter int PHASES   = 4,
    parameter int SPEED_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               dir_i,
    input  logic [SPEED_W-1:0] speed_i,
    input  logic               one_turn_i,
    output logic [PHASES-1:0]  phase_no,
    output logic               done_o
);
    import stp_pkg::*;

    typedef struct packed {
        stp_state_e st;
        logic       done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic load_w, en_w, tick_w, wrap_w;
    logic [PHASES-1:0] pat_w;

    assign load_w = (ctl_q.st == ST_IDLE) && run_i;
    assign en_w   = (ctl_q.st == ST_RUN) && run_i;

    step_timer #(.PRESCALE(PRESCALE), .SPEED_W(SPEED_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load_i(load_w), .en_i(en_w),
        .speed_i(speed_i), .tick_o(tick_w));

    phase_rotator #(.PHASES(PHASES)) u_rot (
        .clk(clk), .rst_n(rst_n), .load_i(load_w), .step_i(tick_w),
        .dir_i(dir_i), .pat_o(pat_w));

    rev_counter #(.STEPS(STEPS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clear_i(load_w), .step_i(tick_w),
        .wrap_o(wrap_w));

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: if (run_i) ctl_d.st = ST_RUN;
            ST_RUN: begin
                if (!run_i) begin
                    ctl_d.st = ST_IDLE;
                end else if (wrap_w && one_turn_i) begin
                    ctl_d.st   = ST_HALT;
                    ctl_d.done = 1'b1;
                end
            end
            ST_HALT: if (!run_i) ctl_d.st = ST_IDLE;
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st   <= ST_IDLE;
            ctl_q.done <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign phase_no = (ctl_q.st == ST_RUN) ? pat_w : '1;
    assign done_o   = ctl_q.done;

    // R1 / R9: run low at an edge releases all coils in the next cycle
    p_idle_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> phase_no == '1);
    // R7: done lasts exactly one cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R7: coils are released while done is shown
    p_done_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> phase_no == '1);
    // R8: once halted, held run keeps coils released
    p_halt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_HALT && run_i) |=> (phase_no == '1 && !done_o));
endmodule

// File: tb/stepper_fullstep_tb.sv
module stepper_fullstep_tb;
    localparam int PRE = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic       dir = 1'b1;
    logic [3:0] speed = 4'd0;
    logic       one_turn = 1'b0;
    logic [3:0] phase_no;
    logic       done_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    // Reference model state
    int   m_st = 0;          // 0 idle, 1 running, 2 halted
    logic [3:0] m_pat = 4'b0111;
    int   m_steps = 0;
    int   m_elapsed = 0;
    int   m_period = 0;
    logic m_done = 1'b0;
    int   done_seen = 0;

    always #4 clk = ~clk;   // 125 MHz

    stepper_fullstep #(.PRESCALE(PRE)) u_dut (
        .clk(clk), .rst_n(rst_n), .run_i(run), .dir_i(dir),
        .speed_i(speed), .one_turn_i(one_turn),
        .phase_no(phase_no), .done_o(done_o));

    function automatic logic [3:0] move(input logic [3:0] p, input logic up);
        int v;
        v = int'(p);
        if (up) v = ((v * 2) % 16) + (v / 8);
        else    v = (v / 2) + ((v % 2) * 8);
        return 4'(v);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_done = 1'b0;
        end else begin
            m_done = 1'b0;
            if (m_st == 0) begin
                if (run) begin
                    m_st = 1; m_pat = 4'b0111; m_steps = 0; m_elapsed = 0;
                    m_period = (int'(speed) + 1) * PRE;
                end
            end else if (m_st == 1) begin
                if (!run) m_st = 0;
                else begin
                    m_elapsed++;
                    if (m_elapsed == m_period) begin
                        m_elapsed = 0;
                        m_period = (int'(speed) + 1) * PRE;
                        m_steps++;
                        m_pat = move(m_pat, dir);
                        if (m_steps == 48) begin
                            m_steps = 0;
                            if (one_turn) begin m_st = 2; m_done = 1'b1; end
                        end
                    end
                end
            end else begin
                if (!run) m_st = 0;
            end
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            check(cur_req, {phase_no, 3'b0, done_o},
                  {(m_st == 1) ? m_pat : 4'b1111, 3'b0, m_done});
            if (done_o) done_seen++;
        end
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int cnt;
        wait_cyc(2);
        check("R1", {phase_no, 3'b0, done_o}, 8'hF0);   // during reset
        rst_n = 1'b1;
        wait_cyc(3);
        check("R1", {phase_no, 3'b0, done_o}, 8'hF0);   // run low after reset

        // R2 / R4 / R5: start upward at speed 1
        cur_req = "R2"; dir = 1'b1; speed = 4'd1; run = 1'b1;
        wait_cyc(1);
        check("R2", {4'b0, phase_no}, 8'h07);
        cur_req = "R4"; wait_cyc(30);
        // R4: reverse direction mid-run
        dir = 1'b0; wait_cyc(40);
        // R5: change speed part-way through a step
        cur_req = "R5"; wait_cyc(2); speed = 4'd4; wait_cyc(60);
        speed = 4'd0; wait_cyc(20);
        // R6: continuous past a full revolution
        cur_req = "R6"; dir = 1'b1; wait_cyc(48 * PRE * 2 + 10);
        check("R6", {7'b0, done_o}, 8'h00);
        // R9: abort and restart
        cur_req = "R9"; run = 1'b0; wait_cyc(1);
        check("R9", {4'b0, phase_no}, 8'h0F);
        wait_cyc(5); run = 1'b1; wait_cyc(1);
        check("R9", {4'b0, phase_no}, 8'h07);
        wait_cyc(20); run = 1'b0; wait_cyc(3);

        // R7: one-turn move at speed 0, count edges to done
        cur_req = "R7"; one_turn = 1'b1; speed = 4'd0; dir = 1'b0;
        done_seen = 0; run = 1'b1; cnt = 0;
        while (!done_o && cnt < 2000) begin wait_cyc(1); cnt++; end
        check("R7", 8'(cnt), 8'(48 * PRE + 1));
        // R8: held run stays halted
        cur_req = "R8"; wait_cyc(100);
        check("R8", {4'b0, phase_no}, 8'h0F);
        check("R7", 8'(done_seen), 8'd1);
        run = 1'b0; wait_cyc(2); run = 1'b1; speed = 4'd1; wait_cyc(1);
        check("R8", {4'b0, phase_no}, 8'h07);
        done_seen = 0;
        wait_cyc(48 * PRE * 2 + 20);
        check("R8", 8'(done_seen), 8'd1);
        cur_req = "R3"; one_turn = 1'b0; run = 1'b0; wait_cyc(3);
        run = 1'b1; wait_cyc(50);
        check("R3", 8'($countones(~phase_no)), 8'd1);
        run = 1'b0; wait_cyc(3);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule